// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block keeps the event flags and the interrupt mask of an I2C bus controller and drives one interrupt request line. The transfer engine reports what happens on the bus as single-cycle event pulses: transmit ready, receive ready, access complete, missing acknowledge, lost arbitration, receive overrun, transmit underrun, address-zero seen, addressed as a slave, and single-byte data. Each pulse sets a sticky flag. A separate level input shows whether the bus is busy, and its status bit follows that input directly.

Software uses a 16-bit register port with a one-bit select. Select 0 is the status view and select 1 is the enable view. Reads are combinational from the current register state. A write takes effect at the clock edge. Writing ones to the status view clears the matching sticky flags. Writing to the enable view sets the mask for the five low events, and only those five can raise an interrupt. The port has no handshake: a write is accepted in every cycle in which `reg_wr` is high.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, every sticky status bit is 0, the enable register reads 0, and `irq` is low.
- R2: An event pulse sets its status bit at the next clock edge. Bit positions: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, address zero 8, addressed as slave 9, transmit underrun 10, receive overrun 11, single-byte data 15. Event input vector order, index 0 to 9, follows the same list.
- R3: A write with `reg_sel`=0 clears each sticky bit whose data bit is 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clear of the same bit happen in the same cycle, the bit stays set.
- R5: Status bit 12 always equals the `bus_busy` input, and a write cannot change it.
- R6: Status bits 5, 6, 7, 13 and 14 always read 0.
- R7: A write with `reg_sel`=1 loads data bits 4..0 into the enable register. A read with `reg_sel`=1 returns the enable register in bits 4..0, with bits 15..5 reading 0.
- R8: `irq` is high exactly while some status bit 0..4 is set together with its enable bit. Status bits 8 and above never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_no_ack | input | 1 | Pulse: acknowledge missing |
| ev_access_done | input | 1 | Pulse: access ready |
| ev_rx_ready | input | 1 | Pulse: receive data ready |
| ev_tx_ready | input | 1 | Pulse: transmit data ready |
| ev_addr_zero | input | 1 | Pulse: address zero seen |
| ev_slave_hit | input | 1 | Pulse: addressed as slave |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_rx_overrun | input | 1 | Pulse: receive overrun |
| ev_single_byte | input | 1 | Pulse: single-byte data |
| bus_busy | input | 1 | Level: bus is busy |
| irq | output | 1 | Interrupt request |

## Verification
Single events, multi-event bursts and all ten events at once are applied. These patterns show whether each pulse lands at its own bit position and whether the reserved positions stay zero. Clear writes using all-ones, a single bit and all-zeros show the difference between a working write-one-to-clear and a write that is ignored or clears everything, while the busy level stays unaffected. A clear that collides with an event on the same bit checks the priority rule. Changes to the enable mask, with events already pending both inside and outside the five low bits, show whether `irq` depends only on the masked low events.

// File: rtl/i2cis_pkg.sv
package i2cis_pkg;
  localparam int REG_W    = 16;
  localparam int EN_W     = 5;
  localparam int EVT_N    = 10;
  localparam int BUSY_POS = 12;

  // Status bit position of each event input index
  function automatic int evt_pos(input int idx);
    case (idx)
      0: evt_pos = 0;
      1: evt_pos = 1;
      2: evt_pos = 2;
      3: evt_pos = 3;
      4: evt_pos = 4;
      5: evt_pos = 8;
      6: evt_pos = 9;
      7: evt_pos = 10;
      8: evt_pos = 11;
      default: evt_pos = 15;
    endcase
  endfunction

  localparam logic [REG_W-1:0] STICKY_MASK = 16'h8F1F;
  localparam logic [REG_W-1:0] UNDEF_MASK  = 16'h60E0;
endpackage

// File: rtl/i2cis_event_bank.sv
module i2cis_event_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q[i] <= 1'b0;
      else if (set_pulse[i]) flag_q[i] <= 1'b1;   // event beats clear
      else if (clr_req[i])   flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cis_enable_reg.sv
module i2cis_enable_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (load) en_q <= din;
  end
endmodule

// File: rtl/i2cis_irq_merge.sv
module i2cis_irq_merge #(
  parameter int W = 5
) (
  input  logic [W-1:0] stat_lo,
  input  logic [W-1:0] mask,
  output logic         irq
);
  assign irq = |(stat_lo & mask);
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2cis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_arb_lost,
  input  logic             ev_no_ack,
  input  logic             ev_access_done,
  input  logic             ev_rx_ready,
  input  logic             ev_tx_ready,
  input  logic             ev_addr_zero,
  input  logic             ev_slave_hit,
  input  logic             ev_tx_underrun,
  input  logic             ev_rx_overrun,
  input  logic             ev_single_byte,
  input  logic             bus_busy,
  output logic             irq
);
  logic [EVT_N-1:0] evt_vec;
  logic [EVT_N-1:0] clr_vec;
  logic [EVT_N-1:0] flag_q;
  logic [EN_W-1:0]  en_q;
  logic [REG_W-1:0] status_view;
  logic             wr_status, wr_enable;
  logic             unused_wbits;

  assign evt_vec = {ev_single_byte, ev_rx_overrun, ev_tx_underrun, ev_slave_hit,
                    ev_addr_zero, ev_tx_ready, ev_rx_ready, ev_access_done,
                    ev_no_ack, ev_arb_lost};

  assign wr_status = reg_wr & ~reg_sel;
  assign wr_enable = reg_wr &  reg_sel;

  for (genvar i = 0; i < EVT_N; i++) begin : g_clr
    assign clr_vec[i] = wr_status & reg_wdata[evt_pos(i)];
  end

  assign unused_wbits = ^(reg_wdata & ~STICKY_MASK);

  i2cis_event_bank #(.N(EVT_N)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_pulse(evt_vec), .clr_req(clr_vec), .flag_q(flag_q)
  );

  i2cis_enable_reg #(.W(EN_W)) u_en (
    .clk(clk), .rst_n(rst_n), .load(wr_enable), .din(reg_wdata[EN_W-1:0]), .en_q(en_q)
  );

  always_comb begin
    status_view = '0;
    for (int i = 0; i < EVT_N; i++) status_view[evt_pos(i)] = flag_q[i];
    status_view[BUSY_POS] = bus_busy;
  end

  assign reg_rdata = reg_sel ? {{(REG_W-EN_W){1'b0}}, en_q} : status_view;

  i2cis_irq_merge #(.W(EN_W)) u_irq (
    .stat_lo(status_view[EN_W-1:0]), .mask(en_q), .irq(irq)
  );
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk
  import i2cis_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [EVT_N-1:0] evt_vec,
  input logic             bus_busy,
  input logic             irq,
  input logic [REG_W-1:0] status_view,
  input logic [EN_W-1:0]  en_q
);
  logic [REG_W-1:0] evt_spread;
  always_comb begin
    evt_spread = '0;
    for (int i = 0; i < EVT_N; i++) evt_spread[evt_pos(i)] = evt_vec[i];
  end

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ((status_view & STICKY_MASK) == '0 && en_q == '0 && !irq));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> ((status_view & $past(evt_spread)) == $past(evt_spread)));

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && evt_vec == '0)
      |=> ((status_view & $past(reg_wdata) & STICKY_MASK) == '0));

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec[1] && reg_wr && !reg_sel && reg_wdata[1]) |=> status_view[1]);

  a_r5_busy_live: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[BUSY_POS] == bus_busy));

  a_r6_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> ((reg_rdata & UNDEF_MASK) == '0));

  a_r7_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (en_q == $past(reg_wdata[EN_W-1:0])));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_vec(evt_vec),
  .bus_busy(bus_busy), .irq(irq), .status_view(status_view), .en_q(en_q)
);

// File: tb/i2c_irq_status_tb_top.sv
`timescale 1ns/100ps
module i2c_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, bus_busy = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [9:0]  ev = '0;
  logic        irq;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  i2c_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_arb_lost(ev[0]), .ev_no_ack(ev[1]), .ev_access_done(ev[2]),
    .ev_rx_ready(ev[3]), .ev_tx_ready(ev[4]), .ev_addr_zero(ev[5]),
    .ev_slave_hit(ev[6]), .ev_tx_underrun(ev[7]), .ev_rx_overrun(ev[8]),
    .ev_single_byte(ev[9]), .bus_busy(bus_busy), .irq(irq)
  );

  // {wsel, wr, wdata, ev, busy, rsel, exp_rdata, exp_irq}
  localparam int NV = 12;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1,1'b1,16'hFFFF,10'h000,1'b0,1'b1,16'h001F,1'b0},
    {1'b0,1'b0,16'h0000,10'h001,1'b0,1'b0,16'h0001,1'b1},
    {1'b0,1'b0,16'h0000,10'h140,1'b0,1'b0,16'h0A01,1'b1},
    {1'b0,1'b1,16'h0001,10'h000,1'b0,1'b0,16'h0A00,1'b0},
    {1'b0,1'b1,16'h0000,10'h000,1'b0,1'b0,16'h0A00,1'b0},
    {1'b0,1'b0,16'h0000,10'h000,1'b1,1'b0,16'h1A00,1'b0},
    {1'b0,1'b1,16'hFFFF,10'h000,1'b1,1'b0,16'h1000,1'b0},
    {1'b0,1'b1,16'h0002,10'h002,1'b1,1'b0,16'h1002,1'b1},
    {1'b1,1'b1,16'h0001,10'h000,1'b1,1'b1,16'h0001,1'b0},
    {1'b0,1'b0,16'h0000,10'h2B0,1'b1,1'b0,16'h9512,1'b0},
    {1'b1,1'b1,16'h0010,10'h000,1'b0,1'b0,16'h8512,1'b1},
    {1'b0,1'b0,16'h0000,10'h3FF,1'b1,1'b0,16'h9F1F,1'b1}
  };

  function automatic string req_of(input int i);
    case (i)
      0: return "R7";  1: return "R2";  2: return "R2";  3: return "R3";
      4: return "R3";  5: return "R5";  6: return "R5";  7: return "R4";
      8: return "R8";  9: return "R2";  10: return "R8"; default: return "R6";
    endcase
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state on both views
    reg_sel = 1'b0; #0.5;
    check16("R1", reg_rdata, 16'h0000);
    check1("R1", irq, 1'b0);
    reg_sel = 1'b1; #0.5;
    check16("R1", reg_rdata, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_sel   = VEC[i][46];
      reg_wr    = VEC[i][45];
      reg_wdata = VEC[i][44:29];
      ev        = VEC[i][28:19];
      bus_busy  = VEC[i][18];
      @(posedge clk);
      #1;
      reg_wr  = 1'b0;
      ev      = '0;
      reg_sel = VEC[i][17];
      #0.5;
      check16(req_of(i), reg_rdata, VEC[i][16:1]);
      check1(req_of(i), irq, VEC[i][0]);
    end

    // R6: reserved bits after every event fired
    reg_sel = 1'b0; #0.2;
    check16("R6", reg_rdata & 16'h60E0, 16'h0000);

    // R1: reset in mid-run clears state, busy stays live
    @(negedge clk);
    bus_busy = 1'b0;
    rst_n = 1'b0;
    #1;
    reg_sel = 1'b0; #0.2;
    check16("R1", reg_rdata, 16'h0000);
    check1("R1", irq, 1'b0);
    reg_sel = 1'b1; #0.2;
    check16("R1", reg_rdata, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule